// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block sits behind the pins of a flow-through synchronous burst SRAM and turns the sampled control inputs into one operation code per clock. Three chip enables, two address strobes, an advance input and the global and byte write inputs are all captured on the rising clock edge. The block reports whether the cycle that just started is idle, a read or a write, and whether it opens a burst, steps to the next word or holds the current word. It also supplies the per-lane write mask and the current burst address. The memory array uses these results during the same cycle, so read data follows the edge with no extra pipeline stage.

Two strobes can open an access. The processor strobe always opens a read; the controller strobe opens a write on the same clock when the write inputs ask for one. A two-bit burst counter walks the low address bits in either linear or interleaved order. A read-drive enable combines the registered cycle state with an asynchronous output-enable input. It keeps the data bus released during writes, after a write until a strobe opens a new read, and during the first read clock that follows an idle cycle.

Top module: `sac_cycle_ctrl`

## Requirements
- R1: While reset is held, the operation code is 0 (idle), the write mask is 0 and the read-drive enable is low.
- R2: When a strobe is accepted and CE1 is high, CE2 is low or CE3 is high, the next cycle's operation code is 0 (idle), the drive enable is low and any burst in progress ends.
- R3: When ADSP is low and CE1 is low with the device selected, the cycle is a read begin (code 1) with a zero write mask, whatever the write inputs and ADSC are.
- R4: When CE1 is high, ADSP is ignored: with ADSC high the clock acts as a cycle with no strobe, so a burst in progress goes on.
- R5: When ADSC is low, ADSP is not accepted and the device is selected, the address input is loaded. The cycle is a write begin (code 2) if a write is indicated, and a read begin (code 1) otherwise.
- R6: A write is indicated when GW is low, which gives mask 4'b1111, or when BWE is low and some byte select is low, which gives the inverse of the selects. Write codes always carry a nonzero mask and read codes a zero mask.
- R7: Mask bit i follows byte select i alone (lane 0 to lane 3), in any combination.
- R8: The drive enable is low during every write cycle (codes 2, 4 and 6), whatever the output enable does.
- R9: After a write, read cycles that continue or hold the burst keep the drive enable low. It returns only when a strobe opens a read.
- R10: The drive enable is low in the first read-begin cycle that follows an idle cycle.
- R11: With no accepted strobe and a burst active, ADV low steps the burst (code 3 for a read, 4 for a write) and ADV high holds the current address (code 5 for a read, 6 for a write).
- R12: The order input picks linear order (0: low two bits are base plus step, modulo 4) or interleaved order (1: low two bits are base XOR step). Upper bits stay fixed and the sequence wraps after four words.
- R13: During an enabled read the drive enable follows the active-low output enable with no clock delay.
- R14: With no burst active and no accepted strobe, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | Chip enable 1, active low; also gates ADSP |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | 4 | Per-lane byte selects, active low |
| addr_i | input | 17 | External address |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| cyc_op_o | output | 3 | Operation code of the current cycle |
| wr_mask_o | output | 4 | Lanes written in the current cycle |
| addr_o | output | 17 | Array address of the current cycle |
| dq_drive_o | output | 1 | Read data may drive the bus |

## Verification
Some rules hold on every clock edge, and the assertions cover them. Strobe priority and deselect decoding are checked against the pins, as is the rule that write codes carry a mask and read codes do not. The drive enable must stay low in write cycles, in locked cycles, in masked cycles and whenever output enable is high. The address must hold on a hold cycle and change only in the low bits on a step. Some behaviour shows only in sequences, so only the bench's directed scenarios can show it. These include the exact linear and interleaved address sequences with their wrap, the bus staying released across reads that follow a write, ADSP being ignored under CE1 high in the middle of a burst, and the lane-to-mask order for chosen select patterns.

// File: rtl/sac_pkg.sv
package sac_pkg;

   typedef enum logic [2:0] {
      OP_IDLE     = 3'd0,
      OP_RD_BEGIN = 3'd1,
      OP_WR_BEGIN = 3'd2,
      OP_RD_CONT  = 3'd3,
      OP_WR_CONT  = 3'd4,
      OP_RD_SUSP  = 3'd5,
      OP_WR_SUSP  = 3'd6
   } sac_op_e;

   function automatic logic op_is_read(input sac_op_e op);
      return (op == OP_RD_BEGIN) || (op == OP_RD_CONT) || (op == OP_RD_SUSP);
   endfunction

   function automatic logic op_is_write(input sac_op_e op);
      return (op == OP_WR_BEGIN) || (op == OP_WR_CONT) || (op == OP_WR_SUSP);
   endfunction

endpackage

// File: rtl/sac_write_decode.sv
module sac_write_decode #(
   parameter int LANES = 4
) (
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   output logic [LANES-1:0] lane_we,
   output logic             wr_hit
);

   if (LANES < 1) begin : g_bad_lanes
      $error("sac_write_decode: LANES must be at least 1");
   end

   // Global write overrides; otherwise each lane needs BWE and its own select.
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_we[i] = !gw_n || (!bwe_n && !bw_n[i]);
   end

   assign wr_hit = |lane_we;

endmodule

// File: rtl/sac_burst_addr.sv
module sac_burst_addr #(
   parameter int ADDR_W  = 17,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              order_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int UPPER_W = ADDR_W - BURST_W;

   if (BURST_W < 1 || ADDR_W <= BURST_W) begin : g_bad_widths
      $error("sac_burst_addr: need 1 <= BURST_W < ADDR_W");
   end

   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] step_q;
   logic [BURST_W-1:0] low_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         step_q <= '0;
      end else if (load) begin
         base_q <= addr_i;
         step_q <= '0;
      end else if (advance) begin
         step_q <= step_q + 1'b1;
      end
   end

   always_comb begin
      if (order_i) low_w = base_q[BURST_W-1:0] ^ step_q;
      else         low_w = base_q[BURST_W-1:0] + step_q;
   end

   assign addr_o = {base_q[ADDR_W-1:BURST_W], low_w};

   a_r5_load_takes_address: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (addr_o == $past(addr_i)));

   a_r11_hold_keeps_address: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !advance) |=> (!$stable(order_i) || $stable(addr_o)));

   a_r12_step_low_bits_only: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load) |=> ($stable(order_i) ->
         (addr_o[ADDR_W-1:BURST_W] == $past(addr_o[ADDR_W-1:BURST_W]) &&
          addr_o != $past(addr_o))));

   logic [UPPER_W-1:0] unused_upper;
   assign unused_upper = addr_o[ADDR_W-1:BURST_W];

endmodule

// File: rtl/sac_cycle_fsm.sv
module sac_cycle_fsm
   import sac_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce1_n,
   input  logic             ce2,
   input  logic             ce3_n,
   input  logic             adsp_n,
   input  logic             adsc_n,
   input  logic             adv_n,
   input  logic             wr_hit,
   input  logic [LANES-1:0] lane_we,
   output sac_op_e          op_q,
   output logic [LANES-1:0] mask_q,
   output logic             lock_q,
   output logic             first_q,
   output logic             load,
   output logic             advance
);

   logic             sel;
   logic             p_take;
   logic             c_take;
   sac_op_e          op_d;
   logic [LANES-1:0] mask_d;
   logic             lock_d;

   assign sel    = !ce1_n && ce2 && !ce3_n;
   assign p_take = !adsp_n && !ce1_n;
   assign c_take = !adsc_n && !p_take;

   always_comb begin
      op_d    = OP_IDLE;
      mask_d  = '0;
      load    = 1'b0;
      advance = 1'b0;
      if (p_take) begin
         if (sel) begin
            op_d = OP_RD_BEGIN;
            load = 1'b1;
         end
      end else if (c_take) begin
         if (sel) begin
            load = 1'b1;
            if (wr_hit) begin
               op_d   = OP_WR_BEGIN;
               mask_d = lane_we;
            end else begin
               op_d = OP_RD_BEGIN;
            end
         end
      end else if (op_q != OP_IDLE) begin
         advance = !adv_n;
         if (wr_hit) begin
            op_d   = adv_n ? OP_WR_SUSP : OP_WR_CONT;
            mask_d = lane_we;
         end else begin
            op_d = adv_n ? OP_RD_SUSP : OP_RD_CONT;
         end
      end
   end

   always_comb begin
      if (op_d == OP_RD_BEGIN || op_d == OP_IDLE) lock_d = 1'b0;
      else if (op_is_write(op_d))                 lock_d = 1'b1;
      else                                        lock_d = lock_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= OP_IDLE;
         mask_q  <= '0;
         lock_q  <= 1'b0;
         first_q <= 1'b0;
      end else begin
         op_q    <= op_d;
         mask_q  <= mask_d;
         lock_q  <= lock_d;
         first_q <= (op_d == OP_RD_BEGIN) && (op_q == OP_IDLE);
      end
   end

   a_r2_strobe_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      ((!adsc_n || (!adsp_n && !ce1_n)) && (ce1_n || !ce2 || ce3_n)) |=> (op_q == OP_IDLE));

   a_r3_adsp_opens_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!adsp_n && !ce1_n && ce2 && !ce3_n) |=> (op_q == OP_RD_BEGIN && mask_q == '0));

   a_r4_adsp_ignored_ce1_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ce1_n && adsc_n && op_q != OP_IDLE) |=> (op_q != OP_IDLE && op_q != OP_RD_BEGIN));

   a_r5_adsc_write_begin: assert property (@(posedge clk) disable iff (!rst_n)
      (adsp_n && !adsc_n && !ce1_n && ce2 && !ce3_n && wr_hit) |=> (op_q == OP_WR_BEGIN));

   a_r6_write_has_mask: assert property (@(posedge clk) disable iff (!rst_n)
      op_is_write(op_q) |-> (mask_q != '0));

   a_r6_read_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (op_is_read(op_q) || op_q == OP_IDLE) |-> (mask_q == '0));

   a_r14_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_IDLE && adsc_n && (adsp_n || ce1_n)) |=> (op_q == OP_IDLE));

endmodule

// File: rtl/sac_drive_gate.sv
module sac_drive_gate
   import sac_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  sac_op_e op,
   input  logic    lock,
   input  logic    first,
   input  logic    oe_n,
   output logic    drive_o
);

   assign drive_o = op_is_read(op) && !lock && !first && !oe_n;

   a_r8_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      op_is_write(op) |-> !drive_o);

   a_r9_locked_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (op_is_write($past(op)) && (op == OP_RD_CONT || op == OP_RD_SUSP)) |-> !drive_o);

   a_r10_first_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op) == OP_IDLE && op == OP_RD_BEGIN) |-> !drive_o);

   a_r13_oe_high_releases: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !drive_o);

endmodule

// File: rtl/sac_cycle_ctrl.sv
module sac_cycle_ctrl
   import sac_pkg::*;
#(
   parameter int ADDR_W  = 17,
   parameter int LANES   = 4,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce1_n,
   input  logic              ce2,
   input  logic              ce3_n,
   input  logic              adsp_n,
   input  logic              adsc_n,
   input  logic              adv_n,
   input  logic              gw_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  bw_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              order_i,
   input  logic              oe_n,
   output logic [2:0]        cyc_op_o,
   output logic [LANES-1:0]  wr_mask_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              dq_drive_o
);

   logic [LANES-1:0] lane_we;
   logic             wr_hit;
   sac_op_e          op_q;
   logic             lock_q;
   logic             first_q;
   logic             load;
   logic             advance;

   sac_write_decode #(.LANES(LANES)) u_wdec (
      .gw_n    (gw_n),
      .bwe_n   (bwe_n),
      .bw_n    (bw_n),
      .lane_we (lane_we),
      .wr_hit  (wr_hit)
   );

   sac_cycle_fsm #(.LANES(LANES)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce1_n   (ce1_n),
      .ce2     (ce2),
      .ce3_n   (ce3_n),
      .adsp_n  (adsp_n),
      .adsc_n  (adsc_n),
      .adv_n   (adv_n),
      .wr_hit  (wr_hit),
      .lane_we (lane_we),
      .op_q    (op_q),
      .mask_q  (wr_mask_o),
      .lock_q  (lock_q),
      .first_q (first_q),
      .load    (load),
      .advance (advance)
   );

   sac_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .advance (advance),
      .addr_i  (addr_i),
      .order_i (order_i),
      .addr_o  (addr_o)
   );

   sac_drive_gate u_drive (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op_q),
      .lock    (lock_q),
      .first   (first_q),
      .oe_n    (oe_n),
      .drive_o (dq_drive_o)
   );

   assign cyc_op_o = op_q;

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (cyc_op_o == 3'd0 && wr_mask_o == '0 && !dq_drive_o));

endmodule

// File: tb/test_sac_cycle_ctrl.sv
module test_sac_cycle_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
   logic        adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
   logic        gw_n = 1'b1, bwe_n = 1'b1;
   logic [3:0]  bw_n = 4'hF;
   logic [16:0] addr_i = '0;
   logic        order_i = 1'b0;
   logic        oe_n = 1'b0;
   logic [2:0]  cyc_op_o;
   logic [3:0]  wr_mask_o;
   logic [16:0] addr_o;
   logic        dq_drive_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   sac_cycle_ctrl i_sac_cycle_ctrl (
      .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
      .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
      .bwe_n(bwe_n), .bw_n(bw_n), .addr_i(addr_i), .order_i(order_i),
      .oe_n(oe_n), .cyc_op_o(cyc_op_o), .wr_mask_o(wr_mask_o),
      .addr_o(addr_o), .dq_drive_o(dq_drive_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int lin_a(input int base, input int k);
      return (base & ~3) | ((base + k) & 3);
   endfunction

   function automatic int il_a(input int base, input int k);
      return (base & ~3) | ((base ^ k) & 3);
   endfunction

   // Apply one clock's inputs, then return at the following negedge.
   task automatic cyc(input logic c1n, input logic c2, input logic c3n,
                      input logic pn, input logic cn, input logic avn,
                      input logic gwn, input logic bwen, input logic [3:0] bwn,
                      input logic [16:0] a);
      ce1_n = c1n; ce2 = c2; ce3_n = c3n;
      adsp_n = pn; adsc_n = cn; adv_n = avn;
      gw_n = gwn; bwe_n = bwen; bw_n = bwn; addr_i = a;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic p_rd(input logic [16:0] a, input logic gwn);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, gwn, 1'b0, 4'h0, a);
   endtask

   task automatic c_acc(input logic [16:0] a, input logic gwn, input logic bwen,
                        input logic [3:0] bwn);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, gwn, bwen, bwn, a);
   endtask

   task automatic nxt(input logic avn, input logic gwn, input logic bwen,
                      input logic [3:0] bwn);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, avn, gwn, bwen, bwn, 17'h0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 op", cyc_op_o, 0);
      chk("R1 mask", wr_mask_o, 0);
      chk("R1 drive", dq_drive_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_linear_read;
      order_i = 1'b0;
      p_rd(17'h00101, 1'b0);
      chk("R3 read begin", cyc_op_o, 1);
      chk("R3 mask ignored", wr_mask_o, 0);
      chk("R5 address", addr_o, 'h101);
      chk("R10 masked first", dq_drive_o, 0);
      for (int k = 1; k <= 4; k++) begin
         nxt(1'b0, 1'b1, 1'b1, 4'hF);
         chk("R11 continue", cyc_op_o, 3);
         chk("R12 linear", addr_o, lin_a('h101, k));
         chk("R13 drive", dq_drive_o, 1);
         if (k == 1) begin
            oe_n = 1'b1; #1;
            chk("R13 oe high", dq_drive_o, 0);
            oe_n = 1'b0; #1;
            chk("R13 oe low", dq_drive_o, 1);
         end
      end
      nxt(1'b1, 1'b1, 1'b1, 4'hF);
      chk("R11 suspend", cyc_op_o, 5);
      chk("R11 hold addr", addr_o, 'h101);
   endtask

   task automatic t_interleave;
      order_i = 1'b1;
      c_acc(17'h0000E, 1'b1, 1'b1, 4'hF);
      chk("R5 read begin", cyc_op_o, 1);
      chk("R10 not after idle", dq_drive_o, 1);
      for (int k = 1; k <= 4; k++) begin
         nxt(1'b0, 1'b1, 1'b1, 4'hF);
         chk("R12 interleaved", addr_o, il_a('hE, k));
      end
      order_i = 1'b0;
   endtask

   task automatic t_adsc_write;
      c_acc(17'h00040, 1'b0, 1'b1, 4'hF);
      chk("R5 write begin", cyc_op_o, 2);
      chk("R6 global mask", wr_mask_o, 'hF);
      chk("R8 no drive", dq_drive_o, 0);
      nxt(1'b0, 1'b1, 1'b1, 4'hF);
      chk("R9 read continue", cyc_op_o, 3);
      chk("R9 still released", dq_drive_o, 0);
      nxt(1'b1, 1'b1, 1'b1, 4'hF);
      chk("R9 suspend released", dq_drive_o, 0);
      p_rd(17'h00044, 1'b1);
      chk("R9 strobe read", cyc_op_o, 1);
      chk("R9 drive back", dq_drive_o, 1);
   endtask

   task automatic t_byte_lanes;
      c_acc(17'h00010, 1'b1, 1'b0, 4'b1010);
      chk("R6 byte write", cyc_op_o, 2);
      chk("R7 lanes 0,2", wr_mask_o, 'b0101);
      c_acc(17'h00010, 1'b1, 1'b1, 4'b0000);
      chk("R6 bwe high read", cyc_op_o, 1);
      chk("R6 bwe high mask", wr_mask_o, 0);
      c_acc(17'h00010, 1'b1, 1'b0, 4'b0111);
      chk("R7 lane 3", wr_mask_o, 'b1000);
   endtask

   task automatic t_priority;
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 17'h00200);
      chk("R3 priority op", cyc_op_o, 1);
      chk("R3 priority mask", wr_mask_o, 0);
   endtask

   task automatic t_ce1_high;
      p_rd(17'h00300, 1'b1);
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 17'h0);
      chk("R4 adsp ignored", cyc_op_o, 3);
      chk("R4 address stepped", addr_o, 'h301);
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 17'h0);
      chk("R2 adsc ce1 high", cyc_op_o, 0);
      chk("R2 drive off", dq_drive_o, 0);
      nxt(1'b0, 1'b1, 1'b1, 4'hF);
      chk("R14 stays idle", cyc_op_o, 0);
   endtask

   task automatic t_ce_deselect;
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 17'h0);
      chk("R2 ce2 low", cyc_op_o, 0);
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 17'h0);
      chk("R2 ce3 high", cyc_op_o, 0);
      chk("R2 no mask", wr_mask_o, 0);
   endtask

   task automatic t_write_after_adsp;
      p_rd(17'h00080, 1'b0);
      chk("R10 after deselect", dq_drive_o, 0);
      nxt(1'b0, 1'b1, 1'b0, 4'b1100);
      chk("R11 write continue", cyc_op_o, 4);
      chk("R7 lanes 0,1", wr_mask_o, 'b0011);
      chk("R12 step", addr_o, 'h81);
      chk("R8 released", dq_drive_o, 0);
      nxt(1'b1, 1'b0, 1'b1, 4'hF);
      chk("R11 write suspend", cyc_op_o, 6);
      chk("R6 gw overrides", wr_mask_o, 'hF);
      chk("R11 suspend addr", addr_o, 'h81);
   endtask

   initial begin
      t_reset();
      t_linear_read();
      t_interleave();
      t_adsc_write();
      t_byte_lanes();
      t_priority();
      t_ce1_high();
      t_ce_deselect();
      t_write_after_adsp();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule